// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block takes four asynchronous external interrupt request pins, brings each into the clock domain, and turns it into a request line. A single 32-bit control word configures how each pin is interpreted. Each pin can follow its level (active high or active low), or it can latch a rising or falling edge. A latched edge stays asserted until software writes a one to that pin's acknowledge bit.

Each pin has its own enable bit. A master enable gates all four request outputs together. Pin 0 drives the critical request output, and a routing bit in the control word must be set for that output to be forwarded. Pins 1 to 3 drive main-group sources 1 to 3.

The control word sits behind a plain synchronous port. A write strobe stores the whole word in one cycle, and the read data reflects the stored state at all times. No data stream crosses the block, so there is no valid/ready handshake. Every pin is plain control.

Top module: `ext_irq_sense_unit`

## Requirements
- R1: After reset every control bit is 0, rd_data reads 0 and crit_req and main_req are 0.
- R2: A write stores the sense fields (pin n at bits 23-2n:22-2n), the enables (pin n at bit 11-n), the master enable (bit 12) and the critical routing bit (bit 0). Acknowledge bits 27:24 and all other bits read back as 0.
- R3: Sense code 0 (level high): the request equals the pin level after a two-flop synchroniser. A pin change made before clock edge k shows on the output after edge k+1.
- R4: Sense code 3 (level low): the request is the inverse of the synchronised pin level.
- R5: Sense code 1 (rising edge): a low-to-high transition of the synchronised pin sets a latch one edge after the synchronised level changes. The request then stays asserted after the pin returns low.
- R6: Sense code 2 (falling edge): only a high-to-low transition sets the latch. A rising transition in this mode leaves the request at 0.
- R7: Writing 1 to bit 27-n clears pin n's latch at that write's clock edge, and acknowledge bits written as 0 leave other latches set. If a new edge arrives in the same cycle as the acknowledge, the latch stays set.
- R8: An enable bit of 0 forces that pin's request to 0 and clears its latch. Edges seen while a pin is disabled are not remembered.
- R9: A master enable (bit 12) of 0 forces all four requests to 0.
- R10: Pin 0 drives crit_req only while bit 0 is 1. Pins 1, 2 and 3 drive main_req[0], main_req[1] and main_req[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 4 | Asynchronous external request pins |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Stored control word (acknowledge bits read as 0) |
| crit_req | output | 1 | Critical-group request from pin 0 |
| main_req | output | 3 | Main-group requests from pins 1 to 3 |

## Verification
The assertions assume that wr_en and wr_data are synchronous to clk. They also assume that the pins only reach the edge detector through the synchroniser, so a latch can rise only one cycle after the synchronised level differs from its delayed copy.

The stimulus changes pins and register inputs on the falling clock edge and holds each pin value for several cycles, so every transition reaches the detector cleanly. The one deliberate collision places an acknowledge write in exactly the cycle when a fresh edge is being detected.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int N_PINS      = 4;
  localparam int REG_W       = 32;
  localparam int SENSE_W     = 2;
  localparam int SENSE_LSB0  = 22;  // field lsb of pin 0, moves down 2 per pin
  localparam int EN_BIT0     = 11;  // enable of pin 0, moves down 1 per pin
  localparam int ACK_BIT0    = 27;  // acknowledge of pin 0, moves down 1 per pin
  localparam int MASTER_BIT  = 12;
  localparam int ROUTE_BIT   = 0;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_RISE   = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_LVL_LO = 2'd3
  } sense_e;

  function automatic logic [REG_W-1:0] stored_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int n = 0; n < N_PINS; n++) begin
      m[SENSE_LSB0-SENSE_W*n +: SENSE_W] = '1;
      m[EN_BIT0-n] = 1'b1;
    end
    m[MASTER_BIT] = 1'b1;
    m[ROUTE_BIT]  = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] ack_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int n = 0; n < N_PINS; n++) m[ACK_BIT0-n] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;
endmodule

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
  import ext_irq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_W-1:0]              wr_data,
  output logic [REG_W-1:0]              rd_data,
  output logic [N_PINS-1:0][SENSE_W-1:0] sense_o,
  output logic [N_PINS-1:0]             en_o,
  output logic [N_PINS-1:0]             ack_o,
  output logic                          master_o,
  output logic                          route_o
);
  localparam logic [REG_W-1:0] KEEP_MASK = stored_mask();
  localparam logic [REG_W-1:0] USED_MASK = stored_mask() | ack_mask();

  logic [N_PINS-1:0][SENSE_W-1:0] sense_q;
  logic [N_PINS-1:0]              en_q;
  logic                           master_q;
  logic                           route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q  <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
      route_q  <= 1'b0;
    end else if (wr_en) begin
      for (int n = 0; n < N_PINS; n++) begin
        sense_q[n] <= wr_data[SENSE_LSB0-SENSE_W*n +: SENSE_W];
        en_q[n]    <= wr_data[EN_BIT0-n];
      end
      master_q <= wr_data[MASTER_BIT];
      route_q  <= wr_data[ROUTE_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int n = 0; n < N_PINS; n++) begin
      rd_data[SENSE_LSB0-SENSE_W*n +: SENSE_W] = sense_q[n];
      rd_data[EN_BIT0-n] = en_q[n];
      ack_o[n] = wr_en & wr_data[ACK_BIT0-n];
    end
    rd_data[MASTER_BIT] = master_q;
    rd_data[ROUTE_BIT]  = route_q;
  end

  assign sense_o  = sense_q;
  assign en_o     = en_q;
  assign master_o = master_q;
  assign route_o  = route_q;

  logic unused_wdata;
  assign unused_wdata = ^(wr_data & ~USED_MASK);

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & KEEP_MASK)); // R2
endmodule

// File: rtl/ext_irq_lane.sv
module ext_irq_lane
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl_i,
  input  logic   en_i,
  input  sense_e sense_i,
  input  logic   ack_i,
  output logic   req_o
);
  logic prev_q;
  logic latch_q;
  logic edge_hit;

  always_comb begin
    unique case (sense_i)
      SENSE_RISE: edge_hit = en_i & lvl_i & ~prev_q;
      SENSE_FALL: edge_hit = en_i & ~lvl_i & prev_q;
      default:    edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      latch_q <= en_i & (edge_hit | (latch_q & ~ack_i));
    end
  end

  always_comb begin
    unique case (sense_i)
      SENSE_LVL_HI: req_o = en_i & lvl_i;
      SENSE_LVL_LO: req_o = en_i & ~lvl_i;
      default:      req_o = en_i & latch_q;
    endcase
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !edge_hit) |=> !latch_q); // R7
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && en_i && !ack_i) |=> latch_q); // R5
  AST_LATCH_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> ($past(lvl_i) != $past(prev_q))); // R6
  AST_DISABLED_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !latch_q); // R8
endmodule

// File: rtl/ext_irq_sense_unit.sv
module ext_irq_sense_unit
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] irq_pin,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              crit_req,
  output logic [N_PINS-2:0] main_req
);
  logic [N_PINS-1:0]              pin_sync;
  logic [N_PINS-1:0][SENSE_W-1:0] sense;
  logic [N_PINS-1:0]              en;
  logic [N_PINS-1:0]              ack;
  logic [N_PINS-1:0]              lane_req;
  logic                           master_en;
  logic                           route_norm;

  ext_irq_sync #(.WIDTH(N_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_pin),
    .sync_o  (pin_sync)
  );

  ext_irq_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .sense_o  (sense),
    .en_o     (en),
    .ack_o    (ack),
    .master_o (master_en),
    .route_o  (route_norm)
  );

  for (genvar n = 0; n < N_PINS; n++) begin : g_lane
    ext_irq_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (pin_sync[n]),
      .en_i    (en[n]),
      .sense_i (sense_e'(sense[n])),
      .ack_i   (ack[n]),
      .req_o   (lane_req[n])
    );
  end

  assign crit_req = master_en & route_norm & lane_req[0];
  assign main_req = {(N_PINS-1){master_en}} & lane_req[N_PINS-1:1];

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[MASTER_BIT] |-> (!crit_req && main_req == '0)); // R9
  AST_CRIT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[ROUTE_BIT] |-> !crit_req); // R10
endmodule

// File: tb/test_ext_irq_sense_unit.sv
`timescale 1ns/1ps
module test_ext_irq_sense_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_pin = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        crit_req;
  logic [2:0]  main_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_sense_unit i_ext_irq_sense_unit (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .crit_req(crit_req), .main_req(main_req)
  );

  localparam logic [31:0] ALL_ACK = 32'h0F00_0000;
  localparam logic [31:0] ON_ALL  = 32'h0000_1F01; // master, 4 enables, route

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] reqs();
    return {28'd0, main_req, crit_req};
  endfunction

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 requests", reqs(), 32'h0);
  endtask

  task automatic t_readback;
    wr(32'hFFFF_FFFF);
    chk("R2 readback all ones", rd_data, 32'h00FF_1F01);
    wr(32'h0042_0A00);
    chk("R2 readback pattern", rd_data, 32'h0042_0A00);
    wr(32'h0);
  endtask

  task automatic t_level_high;
    wr(ON_ALL);                       // all sense codes 0
    irq_pin = 4'b0001;
    cyc(1);
    chk("R3 not yet through synchroniser", reqs(), 32'h0);
    cyc(1);
    chk("R3 level high after two edges", reqs(), 32'h1);
    irq_pin = 4'b1010;
    cyc(3);
    chk("R3 pins 1 and 3", reqs(), 32'b1010);
    irq_pin = 4'b0000;
    cyc(3);
    chk("R3 level released", reqs(), 32'h0);
  endtask

  task automatic t_level_low;
    wr(ON_ALL | 32'h00FF_0000);       // code 3 on every pin
    cyc(3);
    chk("R4 low pins request", reqs(), 32'hF);
    irq_pin = 4'b0110;
    cyc(3);
    chk("R4 high pins quiet", reqs(), 32'b1001);
    irq_pin = 4'b0000;
    cyc(3);
  endtask

  task automatic t_rising;
    wr(ON_ALL | 32'h0055_0000 | ALL_ACK); // code 1 on every pin
    cyc(2);
    chk("R5 idle", reqs(), 32'h0);
    irq_pin = 4'b0100;
    cyc(2);
    chk("R5 edge not yet latched", reqs(), 32'h0);
    cyc(1);
    chk("R5 rising edge latched", reqs(), 32'b0100);
    irq_pin = 4'b0000;
    cyc(4);
    chk("R5 held after pin falls", reqs(), 32'b0100);
    irq_pin = 4'b0010;
    cyc(4);
    irq_pin = 4'b0000;
    chk("R5 two latches", reqs(), 32'b0110);
    wr(ON_ALL | 32'h0055_0000 | (32'h1 << 26)); // ack pin 1 only
    chk("R7 ack one pin, other stays", reqs(), 32'b0100);
    wr(ON_ALL | 32'h0055_0000 | (32'h1 << 25)); // ack pin 2
    chk("R7 ack clears pin 2", reqs(), 32'h0);
  endtask

  task automatic t_ack_collide;
    irq_pin = 4'b0010;
    cyc(4);
    irq_pin = 4'b0000;
    cyc(4);
    chk("R7 pin 1 latched", reqs(), 32'b0010);
    irq_pin = 4'b0010;
    cyc(2);                           // detector sees the edge this cycle
    wr(ON_ALL | 32'h0055_0000 | (32'h1 << 26));
    chk("R7 edge with ack keeps latch", reqs(), 32'b0010);
    irq_pin = 4'b0000;
    cyc(3);
    wr(ON_ALL | 32'h0055_0000 | ALL_ACK);
    chk("R7 plain ack clears", reqs(), 32'h0);
  endtask

  task automatic t_falling;
    wr(ON_ALL | 32'h00AA_0000 | ALL_ACK); // code 2 on every pin
    irq_pin = 4'b1111;
    cyc(4);
    chk("R6 rising ignored", reqs(), 32'h0);
    irq_pin = 4'b0111;
    cyc(3);
    chk("R6 falling pin 3 latched", reqs(), 32'b1000);
    irq_pin = 4'b0000;
    cyc(4);
    wr(ON_ALL | 32'h00AA_0000 | ALL_ACK);
    chk("R6 cleared", reqs(), 32'h0);
  endtask

  task automatic t_enable;
    wr(32'h0055_1801 | ALL_ACK);      // rising, only pin 0 enabled
    irq_pin = 4'b1111;
    cyc(4);
    chk("R8 only enabled pin", reqs(), 32'h1);
    wr(ON_ALL | 32'h0055_0000);
    chk("R8 disabled edges forgotten", reqs(), 32'h1);
    irq_pin = 4'b0000;
    cyc(3);
    wr(ON_ALL | 32'h0055_0000 | ALL_ACK);
  endtask

  task automatic t_master;
    wr(32'h0000_0F01);                // level high, master off
    irq_pin = 4'b1111;
    cyc(4);
    chk("R9 master off silences all", reqs(), 32'h0);
    wr(ON_ALL);
    chk("R9 master on", reqs(), 32'hF);
  endtask

  task automatic t_route;
    wr(32'h0000_1F00);                // route bit cleared
    chk("R10 critical withheld", reqs(), 32'b1110);
    irq_pin = 4'b0001;
    cyc(3);
    chk("R10 pin 0 only, withheld", reqs(), 32'h0);
    wr(ON_ALL);
    chk("R10 pin 0 to crit_req", reqs(), 32'h1);
    irq_pin = 4'b0000;
    cyc(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_readback();
    t_level_high();
    t_level_low();
    t_rising();
    t_ack_collide();
    t_falling();
    t_enable();
    t_master();
    t_route();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule